// File: doc/BRIEF.md
# Indirect Register Pointer Access Port

This block is the host-facing side of a serial controller's register file. The host sees only two byte-wide locations: a control location and a data location. Register 0 answers at the control location directly. Any other register takes two steps. First the host writes that register's index to the control location. The next control access, read or write, then reaches the selected register, and the pointer drops back to zero.

A write to register 0 has three fields:

- The low index bits give the pointer value.
- Bits 5:3 hold a command code. Code 1 lifts the pointer into the upper half of the bank. Codes 2 to 7 fire one-cycle action pulses.
- Bits 7:6 hold a CRC/end-of-message reset code, also issued as a pulse.

The block keeps 16 write registers and one auxiliary register, and drives all of them as outputs to the rest of the controller. Control reads return status bytes supplied from outside. When the auxiliary register's readback bit is set, a chosen subset of indices returns the host's own written values instead of status.

The data location bypasses the pointer entirely. A write there hands a byte to the transmitter. A read there takes the byte offered by the receiver.

Top module: `sccp_regport`

## Requirements
- R1: After reset the pointer is 0, every write register and the auxiliary register read 0, and no command, CRC, transmit-load or receive-take pulse is asserted.
- R2: A control write while the pointer is 0 loads the pointer from bits 2:0. The following control write stores its byte in the selected register and returns the pointer to 0.
- R3: A register-0 write whose bits 5:3 equal 1 sets pointer bit 3, so that index bits 2:0 select registers 8 to 15.
- R4: A register-0 write with code c = 2..7 in bits 5:3 raises `cmd_pulse_o[c-2]` for exactly the next cycle. The bit order is: external-status reset, abort, receive interrupt on next character, transmit-interrupt clear, error reset, highest in-service reset.
- R5: A register-0 write with code k = 1..3 in bits 7:6 raises `crc_pulse_o[k-1]` for exactly the next cycle. The bit order is: receive CRC reset, transmit CRC reset, end-of-message latch reset.
- R6: A control read with the pointer at 0 returns status byte 0 and leaves the pointer at 0.
- R7: A control read with pointer p ≠ 0 returns status byte p (or the readback value of R11), and the pointer returns to 0.
- R8: A data-location write presents the byte on `tx_data_o` with a one-cycle `tx_load_o` in the following cycle, and does not change the pointer.
- R9: A data-location read returns `rx_data_i` combinationally, raises `rx_take_o` in the following cycle, and does not change the pointer.
- R10: A write to register 7 lands in the auxiliary register instead of register 7 while bit 0 of register 15 is set.
- R11: While auxiliary bit 6 is set, control reads of indices 3, 4, 5 and 10 return the stored write-register value; all other indices, and all indices when the bit is clear, return status.
- R12: A register-0 write keeps only its pointer bits 2:0 in stored register 0; the command fields are not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access select |
| bus_addr | input | 1 | 0 = control location, 1 = data location |
| bus_wr | input | 1 | Write strobe (wins over read) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the read strobe is high |
| stat_i | input | 128 | Status bytes, byte k at bits 8k+7:8k |
| rx_data_i | input | 8 | Receive buffer byte |
| wr_regs_o | output | 128 | Write registers, register k at bits 8k+7:8k |
| aux_o | output | 8 | Auxiliary register |
| cmd_pulse_o | output | 6 | Register-0 command pulses (R4 order) |
| crc_pulse_o | output | 3 | CRC/end-of-message reset pulses (R5 order) |
| tx_data_o | output | 8 | Last byte written to the data location |
| tx_load_o | output | 1 | Transmit buffer load pulse |
| rx_take_o | output | 1 | Receive buffer taken pulse |

## Verification
Most faults in this block come from a pointer that fails to clear, or that clears too early. Neither shows on its own access; both surface one access later. A stuck pointer sends the next byte into the wrong register, visible on `wr_regs_o` one cycle after that write. It also turns a synchronising status read into a read of some other register. An extra pointer bit from a mis-decoded command shifts a write into the upper half of the bank. A command field that is wrongly latched shows as pulses that last more than one cycle, or as stray bits in stored register 0. Readback-gating faults show directly as status bytes swapped for written values on `bus_rdata`.

// File: rtl/sccp_pkg.sv
package sccp_pkg;

    localparam int BYTE_W        = 8;
    localparam int CMD_LSB       = 3;
    localparam int CRC_LSB       = 6;
    localparam int NUM_CMD_PULSE = 6;
    localparam int NUM_CRC_PULSE = 3;
    localparam int FIRST_ACTION  = 2;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_HIGH    = 3'd1,
        CMD_EXTRST  = 3'd2,
        CMD_ABORT   = 3'd3,
        CMD_RXNEXT  = 3'd4,
        CMD_TXCLR   = 3'd5,
        CMD_ERRRST  = 3'd6,
        CMD_IUSRST  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        CRC_NONE = 2'd0,
        CRC_RX   = 2'd1,
        CRC_TX   = 2'd2,
        CRC_EOM  = 2'd3
    } crc_e;

    typedef struct packed {
        logic ctl_wr;
        logic ctl_rd;
        logic dat_wr;
        logic dat_rd;
    } acc_t;

endpackage

// File: rtl/sccp_acc_decode.sv
module sccp_acc_decode
    import sccp_pkg::*;
(
    input  logic bus_sel,
    input  logic bus_addr,
    input  logic bus_wr,
    input  logic bus_rd,
    output acc_t acc
);

    always_comb begin
        acc        = '0;
        acc.ctl_wr = bus_sel & ~bus_addr & bus_wr;
        acc.ctl_rd = bus_sel & ~bus_addr & bus_rd & ~bus_wr;
        acc.dat_wr = bus_sel &  bus_addr & bus_wr;
        acc.dat_rd = bus_sel &  bus_addr & bus_rd & ~bus_wr;
    end

endmodule

// File: rtl/sccp_ptr_ctrl.sv
module sccp_ptr_ctrl
    import sccp_pkg::*;
#(
    parameter  int NREG = 16,
    localparam int IW   = $clog2(NREG),
    localparam int LW   = IW - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_wr,
    input  logic                     ctl_rd,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [IW-1:0]            ptr_q,
    output logic                     wr_en,
    output logic [IW-1:0]            wr_idx,
    output logic [NUM_CMD_PULSE-1:0] cmd_pulse,
    output logic [NUM_CRC_PULSE-1:0] crc_pulse
);

    typedef struct packed {
        logic [IW-1:0]            ptr;
        logic [NUM_CMD_PULSE-1:0] cmd;
        logic [NUM_CRC_PULSE-1:0] crc;
    } state_t;

    state_t s_d, s_q;
    cmd_e   code;
    crc_e   ccode;

    always_comb begin
        code   = cmd_e'(wdata[CMD_LSB +: 3]);
        ccode  = crc_e'(wdata[CRC_LSB +: 2]);
        s_d    = s_q;
        s_d.cmd = '0;
        s_d.crc = '0;
        wr_en  = 1'b0;
        wr_idx = s_q.ptr;
        if (ctl_wr) begin
            wr_en = 1'b1;
            if (s_q.ptr == '0) begin
                s_d.ptr = {code == CMD_HIGH, wdata[LW-1:0]};
                for (int k = 0; k < NUM_CMD_PULSE; k++) begin
                    s_d.cmd[k] = (int'(code) == k + FIRST_ACTION);
                end
                for (int k = 0; k < NUM_CRC_PULSE; k++) begin
                    s_d.crc[k] = (int'(ccode) == k + 1);
                end
            end else begin
                s_d.ptr = '0;
            end
        end else if (ctl_rd) begin
            s_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr_q     = s_q.ptr;
    assign cmd_pulse = s_q.cmd;
    assign crc_pulse = s_q.crc;

endmodule

// File: rtl/sccp_wr_bank.sv
module sccp_wr_bank
    import sccp_pkg::*;
#(
    parameter  int NREG    = 16,
    parameter  int AUX_IDX = 7,
    parameter  int AUX_SEL = 15,
    parameter  int AUX_BIT = 0,
    localparam int IW      = $clog2(NREG),
    localparam int LW      = IW - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]      wdata,
    output logic [NREG*BYTE_W-1:0] regs_o,
    output logic [BYTE_W-1:0]      aux_o
);

    localparam logic [BYTE_W-1:0] PTR_MASK = BYTE_W'((1 << LW) - 1);

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] bank;
        logic [BYTE_W-1:0]           aux;
    } state_t;

    state_t s_d, s_q;
    logic   aux_route;

    always_comb begin
        s_d       = s_q;
        aux_route = (wr_idx == IW'(AUX_IDX)) && s_q.bank[AUX_SEL][AUX_BIT];
        if (wr_en) begin
            if (aux_route) begin
                s_d.aux = wdata;
            end else if (wr_idx == '0) begin
                s_d.bank[0] = wdata & PTR_MASK;
            end else begin
                s_d.bank[wr_idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[g*BYTE_W +: BYTE_W] = s_q.bank[g];
    end
    assign aux_o = s_q.aux;

endmodule

// File: rtl/sccp_rd_mux.sv
module sccp_rd_mux
    import sccp_pkg::*;
#(
    parameter  int              NREG    = 16,
    parameter  logic [NREG-1:0] RB_MASK = 16'h0438,
    localparam int              IW      = $clog2(NREG)
) (
    input  logic                   bus_addr,
    input  logic [IW-1:0]          ptr,
    input  logic                   rb_en,
    input  logic [NREG*BYTE_W-1:0] stat_i,
    input  logic [NREG*BYTE_W-1:0] regs_i,
    input  logic [BYTE_W-1:0]      rx_data_i,
    output logic [BYTE_W-1:0]      rdata
);

    logic [NREG-1:0][BYTE_W-1:0] stat_a;
    logic [NREG-1:0][BYTE_W-1:0] regs_a;

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign stat_a[g] = stat_i[g*BYTE_W +: BYTE_W];
        assign regs_a[g] = regs_i[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        if (bus_addr) begin
            rdata = rx_data_i;
        end else if (rb_en && RB_MASK[ptr]) begin
            rdata = regs_a[ptr];
        end else begin
            rdata = stat_a[ptr];
        end
    end

endmodule

// File: rtl/sccp_regport.sv
module sccp_regport
    import sccp_pkg::*;
#(
    parameter  int              NREG    = 16,
    parameter  int              AUX_IDX = 7,
    parameter  int              AUX_SEL = 15,
    parameter  int              AUX_BIT = 0,
    parameter  int              RB_BIT  = 6,
    parameter  logic [NREG-1:0] RB_MASK = 16'h0438,
    localparam int              IW      = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [NREG*BYTE_W-1:0]   stat_i,
    input  logic [BYTE_W-1:0]        rx_data_i,
    output logic [NREG*BYTE_W-1:0]   wr_regs_o,
    output logic [BYTE_W-1:0]        aux_o,
    output logic [NUM_CMD_PULSE-1:0] cmd_pulse_o,
    output logic [NUM_CRC_PULSE-1:0] crc_pulse_o,
    output logic [BYTE_W-1:0]        tx_data_o,
    output logic                     tx_load_o,
    output logic                     rx_take_o
);

    acc_t          acc;
    logic [IW-1:0] ptr_q;
    logic          wr_en;
    logic [IW-1:0] wr_idx;

    typedef struct packed {
        logic [BYTE_W-1:0] tx_data;
        logic              tx_load;
        logic              rx_take;
    } dat_t;

    dat_t d_d, d_q;

    sccp_acc_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .acc      (acc)
    );

    sccp_ptr_ctrl #(.NREG(NREG)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (acc.ctl_wr),
        .ctl_rd    (acc.ctl_rd),
        .wdata     (bus_wdata),
        .ptr_q     (ptr_q),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .cmd_pulse (cmd_pulse_o),
        .crc_pulse (crc_pulse_o)
    );

    sccp_wr_bank #(
        .NREG    (NREG),
        .AUX_IDX (AUX_IDX),
        .AUX_SEL (AUX_SEL),
        .AUX_BIT (AUX_BIT)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wdata  (bus_wdata),
        .regs_o (wr_regs_o),
        .aux_o  (aux_o)
    );

    sccp_rd_mux #(.NREG(NREG), .RB_MASK(RB_MASK)) u_rd (
        .bus_addr  (bus_addr),
        .ptr       (ptr_q),
        .rb_en     (aux_o[RB_BIT]),
        .stat_i    (stat_i),
        .regs_i    (wr_regs_o),
        .rx_data_i (rx_data_i),
        .rdata     (bus_rdata)
    );

    always_comb begin
        d_d         = d_q;
        d_d.tx_load = acc.dat_wr;
        d_d.rx_take = acc.dat_rd;
        if (acc.dat_wr) d_d.tx_data = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign tx_data_o = d_q.tx_data;
    assign tx_load_o = d_q.tx_load;
    assign rx_take_o = d_q.rx_take;

endmodule

// File: rtl/sccp_regport_chk.sv
module sccp_regport_chk #(
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr,
    input logic          ctl_rd,
    input logic          dat_wr,
    input logic          dat_rd,
    input logic [IW-1:0] ptr,
    input logic [5:0]    cmd_pulse,
    input logic [2:0]    crc_pulse,
    input logic          tx_load,
    input logic          rx_take
);

    assert_wr_clears_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ptr != '0) |=> (ptr == '0));

    assert_rd_clears_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && ptr != '0) |=> (ptr == '0));

    assert_sync_read_keeps_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && ptr == '0) |=> (ptr == '0));

    assert_cmd_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pulse));

    assert_cmd_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != '0) |-> $past(ctl_wr && ptr == '0));

    assert_crc_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_pulse != '0) |-> $past(ctl_wr && ptr == '0));

    assert_data_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr || dat_rd) |=> $stable(ptr));

    assert_tx_load_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(dat_wr));

    assert_rx_take_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> $past(dat_rd));

endmodule

bind sccp_regport sccp_regport_chk #(.IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (acc.ctl_wr),
    .ctl_rd    (acc.ctl_rd),
    .dat_wr    (acc.dat_wr),
    .dat_rd    (acc.dat_rd),
    .ptr       (ptr_q),
    .cmd_pulse (cmd_pulse_o),
    .crc_pulse (crc_pulse_o),
    .tx_load   (tx_load_o),
    .rx_take   (rx_take_o)
);

// File: tb/sccp_regport_tb.sv
module sccp_regport_tb;

    localparam int NREG = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_addr = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [NREG*8-1:0] stat_i;
    logic [7:0]        rx_data_i = '0;
    logic [NREG*8-1:0] wr_regs_o;
    logic [7:0]        aux_o;
    logic [5:0]        cmd_pulse_o;
    logic [2:0]        crc_pulse_o;
    logic [7:0]        tx_data_o;
    logic              tx_load_o;
    logic              rx_take_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;

    sccp_regport u_dut (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .stat_i (stat_i), .rx_data_i (rx_data_i),
        .wr_regs_o (wr_regs_o), .aux_o (aux_o),
        .cmd_pulse_o (cmd_pulse_o), .crc_pulse_o (crc_pulse_o),
        .tx_data_o (tx_data_o), .tx_load_o (tx_load_o), .rx_take_o (rx_take_o)
    );

    function automatic logic [7:0] stat_val(int k);
        return 8'((k * 17) ^ 8'h5C);
    endfunction

    function automatic logic [7:0] reg_of(int k);
        return wr_regs_o[k*8 +: 8];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One access; returns at the negedge after the capturing edge.
    task automatic bus_op(logic a, logic w, logic r, logic [7:0] wd, output logic [7:0] rdv);
        @(negedge clk);
        bus_sel = 1'b1; bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = wd;
        #1 rdv = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic ctl_wr(logic [7:0] v);
        logic [7:0] dummy;
        bus_op(1'b0, 1'b1, 1'b0, v, dummy);
    endtask

    task automatic ctl_rd(output logic [7:0] v);
        bus_op(1'b0, 1'b0, 1'b1, 8'h00, v);
    endtask

    task automatic reg_wr(int idx, logic [7:0] v);
        ctl_wr(8'(idx & 7) | ((idx >= 8) ? 8'h08 : 8'h00));
        ctl_wr(v);
    endtask

    task automatic t_reset;
        check("R1 regs", wr_regs_o[31:0] | wr_regs_o[63:32] | wr_regs_o[95:64] | wr_regs_o[127:96], 0);
        check("R1 aux", aux_o, 0);
        check("R1 pulses", {cmd_pulse_o, crc_pulse_o, tx_load_o, rx_take_o}, 0);
        ctl_rd(rd);
        check("R1 ptr zero", rd, stat_val(0));
    endtask

    task automatic t_indexed_write;
        ctl_wr(8'h03);
        ctl_wr(8'h5A);
        check("R2 reg3", reg_of(3), 8'h5A);
        check("R12 reg0 keeps index only", reg_of(0), 8'h03);
        ctl_wr(8'h04);
        ctl_wr(8'h77);
        check("R2 reg4", reg_of(4), 8'h77);
        check("R2 reg3 untouched", reg_of(3), 8'h5A);
        ctl_rd(rd);
        check("R2 ptr back to 0", rd, stat_val(0));
    endtask

    task automatic t_point_high;
        ctl_wr(8'h0A);
        ctl_wr(8'hC3);
        check("R3 reg10", reg_of(10), 8'hC3);
        check("R3 reg2 untouched", reg_of(2), 8'h00);
        check("R12 reg0 drops command", reg_of(0), 8'h02);
        ctl_wr(8'h0C);
        ctl_rd(rd);
        check("R3 read reg12", rd, stat_val(12));
    endtask

    task automatic t_commands;
        ctl_wr(8'h10);
        check("R4 ext reset pulse", cmd_pulse_o, 6'b000001);
        @(negedge clk);
        check("R4 pulse one cycle", cmd_pulse_o, 6'b000000);
        ctl_wr(8'h38);
        check("R4 ius reset pulse", cmd_pulse_o, 6'b100000);
        ctl_rd(rd);
        check("R4 ptr stays 0", rd, stat_val(0));
        ctl_wr(8'h80);
        check("R5 tx crc pulse", {cmd_pulse_o, crc_pulse_o}, {6'b0, 3'b010});
        ctl_wr(8'h68);
        check("R5 combined crc+cmd", {cmd_pulse_o, crc_pulse_o}, {6'b001000, 3'b001});
        @(negedge clk);
        check("R5 pulse one cycle", crc_pulse_o, 3'b000);
    endtask

    task automatic t_reads;
        ctl_rd(rd);
        check("R6 sync read", rd, stat_val(0));
        ctl_rd(rd);
        check("R6 sync read repeat", rd, stat_val(0));
        ctl_wr(8'h02);
        ctl_rd(rd);
        check("R7 read reg2", rd, stat_val(2));
        ctl_rd(rd);
        check("R7 ptr cleared", rd, stat_val(0));
    endtask

    task automatic t_data;
        ctl_wr(8'h05);
        bus_op(1'b1, 1'b1, 1'b0, 8'h3C, rd);
        check("R8 tx data", tx_data_o, 8'h3C);
        check("R8 tx load", tx_load_o, 1'b1);
        @(negedge clk);
        check("R8 tx load one cycle", tx_load_o, 1'b0);
        ctl_wr(8'h99);
        check("R8 ptr held through data write", reg_of(5), 8'h99);
        rx_data_i = 8'h5E;
        ctl_wr(8'h06);
        bus_op(1'b1, 1'b0, 1'b1, 8'h00, rd);
        check("R9 rx data", rd, 8'h5E);
        check("R9 rx take", rx_take_o, 1'b1);
        ctl_wr(8'h21);
        check("R9 ptr held through data read", reg_of(6), 8'h21);
    endtask

    task automatic t_aux_and_readback;
        reg_wr(7, 8'h11);
        check("R10 reg7 direct", reg_of(7), 8'h11);
        check("R10 aux untouched", aux_o, 8'h00);
        reg_wr(15, 8'h01);
        reg_wr(7, 8'h40);
        check("R10 aux loaded", aux_o, 8'h40);
        check("R10 reg7 kept", reg_of(7), 8'h11);
        ctl_wr(8'h03);
        ctl_rd(rd);
        check("R11 readback reg3", rd, 8'h5A);
        ctl_wr(8'h0A);
        ctl_rd(rd);
        check("R11 readback reg10", rd, 8'hC3);
        ctl_wr(8'h02);
        ctl_rd(rd);
        check("R11 reg2 not readable", rd, stat_val(2));
        reg_wr(7, 8'h00);
        ctl_wr(8'h03);
        ctl_rd(rd);
        check("R11 readback off", rd, stat_val(3));
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) stat_i[k*8 +: 8] = stat_val(k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_indexed_write;
        t_point_high;
        t_commands;
        t_reads;
        t_data;
        t_aux_and_readback;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule